// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block sits beside the protocol engine of a serial-bus slave and guards it against a bus that is left stuck with its clock line low. It takes the already synchronized clock and data lines, cleans short noise pulses off both, and recognises the bus start and stop conditions. Between a start and the following stop it measures how long the clock line has been low without interruption; any high interval on the clock line throws the measurement away and it begins again at the next low phase.

When the clock line has stayed low for the configured time (30 ms by default, inside the allowed 25 ms to 35 ms window), the monitor issues a single-cycle reset pulse to the slave's protocol state machine and raises an override that forces the slave to let go of the data line. The override stays up, and the monitor stays disarmed, until the next start condition appears on the bus. Time is counted in milliseconds, derived from the system clock by a prescaler whose division ratio is a parameter.

Top module: `smbus_lowtime_guard`

## Requirements
- R1: A start condition is the filtered data line going from 1 to 0 while the filtered clock line is 1 in both the previous and the current cycle; a stop condition is the filtered data line going from 0 to 1 under the same clock condition.
- R2: The low-time measurement is armed by a start condition and disarmed by a stop condition; while disarmed, no amount of clock-low time produces a timeout.
- R3: Any interval in which the filtered clock line is 1 clears the measured low time, so only one uninterrupted low phase counts towards a timeout.
- R4: A timeout occurs once the filtered clock line has been low for TICK_CYCLES x TIMEOUT_MS consecutive system clock cycles while armed (defaults: 50000 cycles per millisecond, 30 ms), and not earlier.
- R5: Each timeout produces `bus_reset` high for exactly one system clock cycle.
- R6: `sda_release` goes to 1 together with the timeout pulse and stays 1 until the next start condition, which returns it to 0.
- R7: After a timeout the monitor stays disarmed, so further clock-low time causes no second pulse until a new start condition.
- R8: A level change on either input that lasts fewer than FILT_CYCLES system clock cycles (default 6, i.e. up to 100 ns at 50 MHz) is ignored: it neither creates a start or stop condition nor interrupts a clock-low phase.
- R9: During and right after reset, `bus_reset` and `sda_release` are 0 and the monitor is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Clock line, already synchronized to `clk` |
| sda_in | input | 1 | Data line, already synchronized to `clk` |
| bus_reset | output | 1 | One-cycle reset request to the slave protocol logic |
| sda_release | output | 1 | Override forcing the slave to release the data line |

## Verification
The two events that can meet within one filter window are the expiry of the low-time count and the clock line being released by the master. The bench provokes this by letting the raw clock line rise a few cycles after the threshold, while the filtered line still reads low, and again well before the threshold. The first case must still give exactly one reset pulse and a held release, the second none, showing that the decision rests on the filtered clock alone.

// File: rtl/lowtime_pkg.sv
// Package: shared types for the clock-low timeout monitor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lowtime_pkg;

    // Arming state of the low-time measurement.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;

    // Bus conditions seen on the filtered lines in one cycle.
    typedef struct packed {
        logic start;
        logic stop;
    } bus_cond_t;

endpackage

// File: rtl/line_deglitch.sv
// Module: line_deglitch
// Passes a new level of a synchronized line on only after it has been
// seen for FILT_CYCLES consecutive clock cycles; shorter pulses vanish.
// Assumes the input is already synchronous to clk and FILT_CYCLES >= 2.
module line_deglitch #(
    parameter int  FILT_CYCLES = 6,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CNT_W = $clog2(FILT_CYCLES);

    logic [CNT_W-1:0] stable_cnt;

    // Count cycles of disagreement and adopt the new level after enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_out  <= IDLE_LEVEL;
            stable_cnt <= '0;
        end else if (raw_in == clean_out) begin
            stable_cnt <= '0;
        end else if (stable_cnt == CNT_W'(FILT_CYCLES - 1)) begin
            clean_out  <= raw_in;
            stable_cnt <= '0;
        end else begin
            stable_cnt <= stable_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bus_condition_detect.sv
// Module: bus_condition_detect
// Flags start (data falls while clock high) and stop (data rises while
// clock high) on the filtered lines. Assumes both inputs are filtered.
module bus_condition_detect
    import lowtime_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_f,
    input  logic      sda_f,
    output bus_cond_t cond
);
    logic scl_q;
    logic sda_q;

    // Keep last cycle's line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode start and stop from data edges under a steady high clock.
    always_comb begin
        cond.start = scl_q & scl_f &  sda_q & ~sda_f;
        cond.stop  = scl_q & scl_f & ~sda_q &  sda_f;
    end
endmodule

// File: rtl/low_time_counter.sv
// Module: low_time_counter
// Prescales the system clock to millisecond ticks and counts ticks while
// run is high; dropping run clears everything. Flags expiry in the cycle
// that completes TICK_CYCLES*TIMEOUT_MS running cycles.
// Assumes TICK_CYCLES >= 2 and TIMEOUT_MS >= 1.
module low_time_counter #(
    parameter int TICK_CYCLES = 50000,
    parameter int TIMEOUT_MS  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int PRE_W = $clog2(TICK_CYCLES);
    localparam int MS_W  = $clog2(TIMEOUT_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);
    localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(TIMEOUT_MS - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [MS_W-1:0]  ms_cnt;
    logic             tick;

    // A tick ends each prescaler period; expiry is the last tick of the window.
    always_comb begin
        tick   = run && (pre_cnt == PRE_LAST);
        expire = tick && (ms_cnt == MS_LAST);
    end

    // Advance the prescaler and millisecond count; clear when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            ms_cnt  <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            ms_cnt  <= expire ? '0 : ms_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/timeout_control.sv
// Module: timeout_control
// Holds the arming state, emits the one-cycle reset pulse on expiry and
// holds the data-release override until the next start condition.
// Assumes start/stop/expire are single-cycle flags from sibling blocks.
module timeout_control
    import lowtime_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_cond_t cond,
    input  logic      expire,
    output logic      armed,
    output logic      reset_pulse,
    output logic      release_hold
);
    arm_state_t state;

    // Arm on start, disarm on stop or expiry; start clears the override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            reset_pulse  <= 1'b0;
            release_hold <= 1'b0;
        end else begin
            reset_pulse <= expire;
            if (cond.start) begin
                state        <= ST_ARMED;
                release_hold <= 1'b0;
            end else if (cond.stop) begin
                state <= ST_IDLE;
            end else if (expire) begin
                state        <= ST_IDLE;
                release_hold <= 1'b1;
            end
        end
    end

    // Expose the arming state as a plain flag.
    always_comb armed = (state == ST_ARMED);
endmodule

// File: rtl/smbus_lowtime_guard.sv
// Module: smbus_lowtime_guard (top)
// Filters the synchronized bus lines, finds start/stop, times clock-low
// phases while armed and on overrun resets the slave and frees the data
// line. Assumes scl_in/sda_in are already synchronized to clk.
module smbus_lowtime_guard
    import lowtime_pkg::*;
#(
    parameter int TICK_CYCLES = 50000,
    parameter int TIMEOUT_MS  = 30,
    parameter int FILT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_reset,
    output logic sda_release
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;
    logic                 scl_filt;
    logic                 sda_filt;
    bus_cond_t            cond;
    logic                 armed;
    logic                 run;
    logic                 expire;

    // Gather the two lines so one filter instance serves each.
    always_comb raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
        line_deglitch #(
            .FILT_CYCLES(FILT_CYCLES),
            .IDLE_LEVEL (1'b1)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_lines[g]),
            .clean_out(clean_lines[g])
        );
    end

    // Split filtered lines and gate the timer on armed clock-low time.
    always_comb begin
        scl_filt = clean_lines[0];
        sda_filt = clean_lines[1];
        run      = armed & ~scl_filt;
    end

    bus_condition_detect u_detect (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(scl_filt),
        .sda_f(sda_filt),
        .cond (cond)
    );

    low_time_counter #(
        .TICK_CYCLES(TICK_CYCLES),
        .TIMEOUT_MS (TIMEOUT_MS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .expire(expire)
    );

    timeout_control u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond        (cond),
        .expire      (expire),
        .armed       (armed),
        .reset_pulse (bus_reset),
        .release_hold(sda_release)
    );
endmodule

// File: rtl/lowtime_guard_checker.sv
// Module: lowtime_guard_checker
// Property checks for smbus_lowtime_guard, attached by bind below.
// Assumes it observes the top's filtered clock, conditions and state.
module lowtime_guard_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic start,
    input logic stop,
    input logic armed,
    input logic bus_reset,
    input logic sda_release
);
    // R5: the reset request never lasts two cycles.
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bus_reset);

    // R6: the override is up whenever the reset pulse is.
    assert_release_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> sda_release);

    // R6: the override is only dropped by a start condition.
    assert_release_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_release && !start) |=> sda_release);

    // R6: a start clears the override and arms the monitor.
    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!sda_release && armed));

    // R2: a stop disarms the monitor.
    assert_stop_disarms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !armed);

    // R2: a disarmed monitor raises no pulse in the next cycle.
    assert_idle_no_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !bus_reset);

    // R7: once the pulse is out the monitor is disarmed.
    assert_expiry_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> !armed);

    // R1: start and stop only appear with the clock line high.
    assert_cond_clock_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start || stop) |-> scl_f);

    // R3: a high clock line never leads to a pulse in the next cycle.
    assert_high_no_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        scl_f |=> !bus_reset);
endmodule

bind smbus_lowtime_guard lowtime_guard_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (scl_filt),
    .start      (cond.start),
    .stop       (cond.stop),
    .armed      (armed),
    .bus_reset  (bus_reset),
    .sda_release(sda_release)
);

// File: tb/test_smbus_lowtime_guard.sv
// Directed bench for smbus_lowtime_guard with a shortened time base.
module test_smbus_lowtime_guard;
    localparam int TICK   = 10;
    localparam int TMO    = 30;
    localparam int FILT   = 6;
    localparam int WINDOW = TICK * TMO;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic bus_reset;
    logic sda_release;
    int   n_checks = 0;
    int   n_fails = 0;
    int   pulse_total = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    smbus_lowtime_guard #(
        .TICK_CYCLES(TICK),
        .TIMEOUT_MS (TMO),
        .FILT_CYCLES(FILT)
    ) i_smbus_lowtime_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl),
        .sda_in     (sda),
        .bus_reset  (bus_reset),
        .sda_release(sda_release)
    );

    // Count cycles with the reset request high, sampled mid-cycle.
    always @(negedge clk) if (bus_reset) pulse_total++;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start condition, then clock low; the low phase begins at return.
    task automatic bus_start();
        scl = 1'b1; sda = 1'b1; wait_cyc(12);
        sda = 1'b0; wait_cyc(12);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        scl = 1'b0; sda = 1'b0; wait_cyc(12);
        scl = 1'b1; wait_cyc(12);
        sda = 1'b1; wait_cyc(12);
    endtask

    task automatic t_reset_state();
        check("R9 bus_reset after reset", bus_reset, 0);
        check("R9 sda_release after reset", sda_release, 0);
    endtask

    task automatic t_basic_timeout();
        int base;
        bus_stop();
        base = pulse_total;
        bus_start();
        wait_cyc(WINDOW - 10);
        check("R4 no pulse before window", pulse_total - base, 0);
        check("R4 release low before window", sda_release, 0);
        wait_cyc(FILT + 20);
        check("R1 R4 R5 one pulse cycle after start", pulse_total - base, 1);
        check("R6 release held after timeout", sda_release, 1);
        // Clock-low time after the timeout must not fire again.
        scl = 1'b1; wait_cyc(20);
        scl = 1'b0; wait_cyc(2 * WINDOW);
        check("R7 no second pulse while disarmed", pulse_total - base, 1);
        check("R6 release still held", sda_release, 1);
        bus_start();
        check("R6 start clears release", sda_release, 0);
        bus_stop();
    endtask

    task automatic t_high_restarts();
        int base = pulse_total;
        bus_start();
        wait_cyc(WINDOW - 50);
        scl = 1'b1; wait_cyc(20);
        scl = 1'b0; wait_cyc(WINDOW - 50);
        check("R3 high interval restarts count", pulse_total - base, 0);
        wait_cyc(80);
        check("R3 R4 timeout on long second phase", pulse_total - base, 1);
        bus_start();
        bus_stop();
    endtask

    task automatic t_not_armed();
        int base = pulse_total;
        scl = 1'b1; sda = 1'b1; wait_cyc(12);
        scl = 1'b0; wait_cyc(2 * WINDOW);
        check("R2 no timeout without start", pulse_total - base, 0);
        scl = 1'b1; wait_cyc(12);
        bus_start();
        bus_stop();
        scl = 1'b0; sda = 1'b1; wait_cyc(2 * WINDOW);
        check("R1 R2 stop disarms", pulse_total - base, 0);
        check("R2 release low after stop", sda_release, 0);
        scl = 1'b1; wait_cyc(12);
    endtask

    task automatic t_glitches();
        int base = pulse_total;
        bus_start();
        wait_cyc(WINDOW - 50);
        scl = 1'b1; wait_cyc(FILT - 2);
        scl = 1'b0; wait_cyc(80);
        check("R8 short clock pulse keeps count", pulse_total - base, 1);
        bus_start();
        bus_stop();
        base = pulse_total;
        sda = 1'b0; wait_cyc(FILT - 2);
        sda = 1'b1; wait_cyc(12);
        scl = 1'b0; wait_cyc(2 * WINDOW);
        check("R8 short data pulse makes no start", pulse_total - base, 0);
        scl = 1'b1; wait_cyc(12);
    endtask

    task automatic t_edge_coincide();
        int base = pulse_total;
        bus_start();
        wait_cyc(WINDOW + 3);
        scl = 1'b1; wait_cyc(30);
        check("R4 R8 raw rise inside filter window still fires", pulse_total - base, 1);
        check("R6 release after late rise", sda_release, 1);
        base = pulse_total;
        bus_start();
        wait_cyc(WINDOW - 20);
        scl = 1'b1; wait_cyc(30);
        check("R3 R4 early rise prevents timeout", pulse_total - base, 0);
        check("R6 release cleared by start", sda_release, 0);
        bus_stop();
    endtask

    initial begin
        wait_cyc(5);
        t_reset_state();
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset_state();
        t_basic_timeout();
        t_high_restarts();
        t_not_armed();
        t_glitches();
        t_edge_coincide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule